// File: doc/BRIEF.md
# CPU Interrupt Acceptance Unit

This unit sits beside the instruction sequencer of an 8-bit CPU core with a 16-bit address space. It takes in a non-maskable request and a maskable request, keeps the two interrupt-enable flags and a two-bit mode register, and records each accepted request as pending. When a request is pending and no service is running, the unit raises `in_service_o`. This tells the sequencer to stop fetching and hand the bus to the unit.

While it is in service, the unit works out the new stack pointer and writes the saved program counter to the stack one byte per cycle. In table mode it also reads a 16-bit vector through the same port. It then pulses a load strobe that carries the new program counter and stack pointer, and gives control back to opcode fetch. The program counter, stack pointer, page register and data-bus byte are sampled on the cycle the request is taken, so the sequencer may let them drift afterwards.

Memory reads are combinational: `mem_rdata_i` must hold the byte at `mem_addr_o` in the same cycle that `mem_re_o` is high.

Top module: `irq_accept_unit`

## Requirements
- R1: A high `nmi_req_i` in any clock cycle sets the non-maskable pending bit and clears IFF1 (`iff1_o`). IFF2 (`iff2_o`) is left unchanged.
- R2: After reset, `iff1_o` and `iff2_o` are 1, the mode is 0, nothing is pending, and `in_service_o`, `mem_we_o`, `mem_re_o`, `pc_load_o` and `mode_err_o` are 0.
- R3: A high `irq_req_i` sets the maskable pending bit only if IFF1 was 1 before that clock edge. Otherwise it is dropped, and no service follows.
- R4: When a pending bit is set and the unit is idle, `in_service_o` rises at the next clock edge. It stays high until the cycle after the load strobe.
- R5: Let SP be the sampled stack pointer. The new stack pointer is SP−2, taken modulo 2^16. On two consecutive cycles the unit writes the high byte of the PC to address SP−1, then the low byte to address SP−2.
- R6: A non-maskable service loads PC = 0x0066.
- R7: The mode register is written with `mode_val_i` when `mode_we_i` is high. Mode code 1 makes a maskable service load PC = 0x0038. Codes 2 and 3 select table mode.
- R8: In mode 0, a maskable service loads PC = 0x0038 and pulses `mode_err_o` for exactly the load cycle.
- R9: In table mode, after the push the unit reads the low vector byte at {page, bus byte with bit 0 forced to 0}, then the high byte at the next address. The PC it loads is {high, low}.
- R10: The final service cycle pulses `pc_load_o` and `sp_load_o` for one cycle with the vector and SP−2. It clears the pending bit that was served, and the unit is idle on the next cycle.
- R11: When both kinds are pending, the non-maskable one is served first. The maskable one stays pending and is served directly after it.
- R12: `ie_we_i` writes `ie_val_i` into both IFF1 and IFF2. If a non-maskable request arrives in the same cycle, its clearing of IFF1 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req_i | input | 1 | Non-maskable request, one latch per high cycle |
| irq_req_i | input | 1 | Maskable request |
| ie_we_i | input | 1 | Write both enable flags |
| ie_val_i | input | 1 | Value for the enable flags |
| mode_we_i | input | 1 | Write the mode register |
| mode_val_i | input | 2 | New mode code |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| page_i | input | 8 | Vector-table page (high address byte) |
| bus_byte_i | input | 8 | Data-bus byte supplying the table offset |
| mem_rdata_i | input | 8 | Combinational read data |
| in_service_o | output | 1 | Sequencer must hold off fetch |
| mem_we_o | output | 1 | Byte write strobe |
| mem_re_o | output | 1 | Byte read strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| pc_load_o | output | 1 | Load new program counter |
| pc_value_o | output | 16 | New program counter |
| sp_load_o | output | 1 | Load new stack pointer |
| sp_value_o | output | 16 | New stack pointer |
| mode_err_o | output | 1 | One-cycle pulse for a mode-0 service |
| iff1_o | output | 1 | Main enable flag |
| iff2_o | output | 1 | Shadow enable flag |

## Verification
Some properties are checked by assertions on every cycle. These cover the latching of a non-maskable request and its clearing of IFF1, the dropping of a masked request, service entry one cycle after a pending bit appears while idle, the falling address across the two push writes, the error pulse landing only on a restart load, and the return to idle after each load.

Other behaviours can only be shown by the bench scenarios, which compare the full write, read and load stream against values computed from the sampled inputs. These are the actual vector values, the contents of the table reads, stack wrap at address zero, the forcing of the offset bit, and the order of back-to-back services when both kinds arrive together.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_HI = 3'd1,
        ST_PUSH_LO = 3'd2,
        ST_RD_LO   = 3'd3,
        ST_RD_HI   = 3'd4,
        ST_LOAD    = 3'd5
    } svc_state_e;
endpackage

// File: rtl/irq_latch.sv
module irq_latch #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req_i,
    input  logic              irq_req_i,
    input  logic              ie_we_i,
    input  logic              ie_val_i,
    input  logic              mode_we_i,
    input  logic [MODE_W-1:0] mode_val_i,
    input  logic              clr_nmi_i,
    input  logic              clr_irq_i,
    output logic              nmi_pend_o,
    output logic              irq_pend_o,
    output logic              iff1_o,
    output logic              iff2_o,
    output logic [MODE_W-1:0] mode_o
);
    typedef struct packed {
        logic              nmi_pend;
        logic              irq_pend;
        logic              iff1;
        logic              iff2;
        logic [MODE_W-1:0] mode;
    } lat_t;

    lat_t q, d;

    always_comb begin
        d = q;
        if (ie_we_i) begin
            d.iff1 = ie_val_i;
            d.iff2 = ie_val_i;
        end
        if (mode_we_i) d.mode = mode_val_i;
        if (clr_nmi_i) d.nmi_pend = 1'b0;
        if (clr_irq_i) d.irq_pend = 1'b0;
        if (irq_req_i && q.iff1) d.irq_pend = 1'b1;
        if (nmi_req_i) begin
            d.nmi_pend = 1'b1;
            d.iff1     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.nmi_pend <= 1'b0;
            q.irq_pend <= 1'b0;
            q.iff1     <= 1'b1;
            q.iff2     <= 1'b1;
            q.mode     <= '0;
        end else begin
            q <= d;
        end
    end

    assign nmi_pend_o = q.nmi_pend;
    assign irq_pend_o = q.irq_pend;
    assign iff1_o     = q.iff1;
    assign iff2_o     = q.iff2;
    assign mode_o     = q.mode;

    // R1
    nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_i |=> (q.nmi_pend && !q.iff1));

    // R3
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_i && !q.iff1 && !q.irq_pend) |=> !q.irq_pend);
endmodule

// File: rtl/irq_svc_seq.sv
module irq_svc_seq
    import irq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          MODE_W    = 2,
    parameter logic [15:0] NMI_VEC   = 16'h0066,
    parameter logic [15:0] RST_VEC   = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pend_i,
    input  logic              irq_pend_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] page_i,
    input  logic [DATA_W-1:0] bus_byte_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              in_service_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_value_o,
    output logic              sp_load_o,
    output logic [ADDR_W-1:0] sp_value_o,
    output logic              clr_nmi_o,
    output logic              clr_irq_o,
    output logic              mode_err_o
);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        svc_state_e        st;
        logic              src_nmi;
        logic              use_table;
        logic              mode0;
        logic [ADDR_W-1:0] sp_new;
        logic [ADDR_W-1:0] pc_save;
        logic [ADDR_W-1:0] tab_addr;
        logic [ADDR_W-1:0] vec;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d            = q;
        mem_we_o     = 1'b0;
        mem_re_o     = 1'b0;
        mem_addr_o   = '0;
        mem_wdata_o  = '0;
        pc_load_o    = 1'b0;
        pc_value_o   = '0;
        sp_load_o    = 1'b0;
        sp_value_o   = '0;
        clr_nmi_o    = 1'b0;
        clr_irq_o    = 1'b0;
        mode_err_o   = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (nmi_pend_i || irq_pend_i) begin
                    d.st        = ST_PUSH_HI;
                    d.src_nmi   = nmi_pend_i;
                    d.use_table = !nmi_pend_i && mode_i[1];
                    d.mode0     = !nmi_pend_i && (mode_i == '0);
                    d.sp_new    = sp_i - ADDR_W'(2);
                    d.pc_save   = pc_i;
                    d.tab_addr  = {page_i[HI_W-1:0], bus_byte_i[DATA_W-1:1], 1'b0};
                end
            end
            ST_PUSH_HI: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = q.sp_new + ADDR_W'(1);
                mem_wdata_o = q.pc_save[ADDR_W-1:DATA_W];
                d.st        = ST_PUSH_LO;
            end
            ST_PUSH_LO: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = q.sp_new;
                mem_wdata_o = q.pc_save[DATA_W-1:0];
                d.vec       = q.src_nmi ? NMI_VEC[ADDR_W-1:0] : RST_VEC[ADDR_W-1:0];
                d.st        = q.use_table ? ST_RD_LO : ST_LOAD;
            end
            ST_RD_LO: begin
                mem_re_o             = 1'b1;
                mem_addr_o           = q.tab_addr;
                d.vec[DATA_W-1:0]    = mem_rdata_i;
                d.st                 = ST_RD_HI;
            end
            ST_RD_HI: begin
                mem_re_o                 = 1'b1;
                mem_addr_o               = q.tab_addr + ADDR_W'(1);
                d.vec[ADDR_W-1:DATA_W]   = mem_rdata_i;
                d.st                     = ST_LOAD;
            end
            ST_LOAD: begin
                pc_load_o  = 1'b1;
                pc_value_o = q.vec;
                sp_load_o  = 1'b1;
                sp_value_o = q.sp_new;
                clr_nmi_o  = q.src_nmi;
                clr_irq_o  = !q.src_nmi;
                mode_err_o = q.mode0;
                d.st       = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_service_o = (q.st != ST_IDLE);

    // R5
    push_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PUSH_HI) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) - ADDR_W'(1)));

    // R8
    err_on_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> (pc_load_o && pc_value_o == RST_VEC[ADDR_W-1:0]));
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter int          MODE_W  = 2,
    parameter logic [15:0] NMI_VEC = 16'h0066,
    parameter logic [15:0] RST_VEC = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_req_i,
    input  logic              irq_req_i,
    input  logic              ie_we_i,
    input  logic              ie_val_i,
    input  logic              mode_we_i,
    input  logic [MODE_W-1:0] mode_val_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] page_i,
    input  logic [DATA_W-1:0] bus_byte_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              in_service_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              pc_load_o,
    output logic [ADDR_W-1:0] pc_value_o,
    output logic              sp_load_o,
    output logic [ADDR_W-1:0] sp_value_o,
    output logic              mode_err_o,
    output logic              iff1_o,
    output logic              iff2_o
);
    logic              nmi_pend, irq_pend, clr_nmi, clr_irq;
    logic [MODE_W-1:0] mode_cur;

    irq_latch #(.MODE_W(MODE_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .nmi_req_i  (nmi_req_i),
        .irq_req_i  (irq_req_i),
        .ie_we_i    (ie_we_i),
        .ie_val_i   (ie_val_i),
        .mode_we_i  (mode_we_i),
        .mode_val_i (mode_val_i),
        .clr_nmi_i  (clr_nmi),
        .clr_irq_i  (clr_irq),
        .nmi_pend_o (nmi_pend),
        .irq_pend_o (irq_pend),
        .iff1_o     (iff1_o),
        .iff2_o     (iff2_o),
        .mode_o     (mode_cur)
    );

    irq_svc_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .MODE_W  (MODE_W),
        .NMI_VEC (NMI_VEC),
        .RST_VEC (RST_VEC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .nmi_pend_i   (nmi_pend),
        .irq_pend_i   (irq_pend),
        .mode_i       (mode_cur),
        .pc_i         (pc_i),
        .sp_i         (sp_i),
        .page_i       (page_i),
        .bus_byte_i   (bus_byte_i),
        .mem_rdata_i  (mem_rdata_i),
        .in_service_o (in_service_o),
        .mem_we_o     (mem_we_o),
        .mem_re_o     (mem_re_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o),
        .pc_load_o    (pc_load_o),
        .pc_value_o   (pc_value_o),
        .sp_load_o    (sp_load_o),
        .sp_value_o   (sp_value_o),
        .clr_nmi_o    (clr_nmi),
        .clr_irq_o    (clr_irq),
        .mode_err_o   (mode_err_o)
    );

    // R4
    take_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_service_o && (nmi_pend || irq_pend)) |=> in_service_o);

    // R10
    load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (in_service_o && sp_load_o) ##1 !in_service_o);
endmodule

// File: tb/tb_irq_accept_unit.sv
module tb_irq_accept_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0, irq_req = 1'b0, ie_we = 1'b0, ie_val = 1'b0, mode_we = 1'b0;
    logic [1:0]  mode_val = '0;
    logic [15:0] pc = '0, sp = '0;
    logic [7:0]  page = '0, bus_byte = '0, mem_rdata;
    logic        in_service, mem_we, mem_re, pc_load, sp_load, mode_err, iff1, iff2;
    logic [15:0] mem_addr, pc_value, sp_value;
    logic [7:0]  mem_wdata;

    always #10 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign mem_rdata = mem_byte(mem_addr);

    irq_accept_unit dut (
        .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi_req), .irq_req_i(irq_req),
        .ie_we_i(ie_we), .ie_val_i(ie_val), .mode_we_i(mode_we), .mode_val_i(mode_val),
        .pc_i(pc), .sp_i(sp), .page_i(page), .bus_byte_i(bus_byte), .mem_rdata_i(mem_rdata),
        .in_service_o(in_service), .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .pc_load_o(pc_load), .pc_value_o(pc_value),
        .sp_load_o(sp_load), .sp_value_o(sp_value), .mode_err_o(mode_err),
        .iff1_o(iff1), .iff2_o(iff2)
    );

    typedef struct {
        bit          is_load;
        logic [15:0] a;
        logic [15:0] d;
        bit          err;
        string       req;
    } item_t;

    item_t exp_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_item(input bit ld, input logic [15:0] a, input logic [15:0] d,
                             input bit err, input string req);
        item_t it;
        it.is_load = ld; it.a = a; it.d = d; it.err = err; it.req = req;
        exp_q.push_back(it);
    endtask

    // driver: expected stream of one service, from the sampled inputs
    task automatic expect_service(input bit nmi, input logic [1:0] mode, input string req);
        logic [15:0] spn, vec, ta;
        spn = sp - 16'd2;
        push_item(1'b0, spn + 16'd1, {8'h00, pc[15:8]}, 1'b0, "R5");
        push_item(1'b0, spn,         {8'h00, pc[7:0]},  1'b0, "R5");
        if (nmi) vec = 16'h0066;
        else if (mode[1]) begin
            ta  = {page, bus_byte[7:1], 1'b0};
            vec = {mem_byte(ta + 16'd1), mem_byte(ta)};
        end else vec = 16'h0038;
        push_item(1'b1, vec, spn, !nmi && mode == 2'd0, req);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (mem_we || pc_load || mode_err)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected activity", {mem_we, pc_load, mode_err}, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    if (!it.is_load) begin
                        check(mem_we && !pc_load, it.req, "write strobe", {mem_we, pc_load}, 2);
                        check(mem_addr == it.a, it.req, "write addr", mem_addr, it.a);
                        check(mem_wdata == it.d[7:0], it.req, "write data", mem_wdata, it.d[7:0]);
                    end else begin
                        check(pc_load && sp_load, it.req, "load strobes", {pc_load, sp_load}, 3);
                        check(pc_value == it.a, it.req, "vector", pc_value, it.a);
                        check(sp_value == it.d, "R5", "new sp", sp_value, it.d);
                        check(mode_err == it.err, "R8", "mode error pulse", mode_err, it.err);
                    end
                end
            end
        end
    end

    task automatic pulse(input bit n, input bit i);
        @(negedge clk);
        nmi_req = n; irq_req = i;
        @(negedge clk);
        nmi_req = 1'b0; irq_req = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); mode_we = 1'b1; mode_val = m;
        @(negedge clk); mode_we = 1'b0;
    endtask

    task automatic set_ie(input bit v);
        @(negedge clk); ie_we = 1'b1; ie_val = v;
        @(negedge clk); ie_we = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (16) @(negedge clk);
        check(exp_q.size() == 0, req, "expected items left", exp_q.size(), 0);
        check(!in_service, "R10", "idle after service", in_service, 0);
    endtask

    task automatic one_irq(input logic [1:0] mode, input string req);
        expect_service(1'b0, mode, req);
        pulse(1'b0, 1'b1);
        check(!in_service, "R4", "not yet in service", in_service, 0);
        @(negedge clk);
        check(in_service, "R4", "in service one cycle after latch", in_service, 1);
        drain(req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check(iff1 && iff2, "R2", "enable flags after reset", {iff1, iff2}, 3);
        check(!in_service && !mem_we && !mem_re && !pc_load && !mode_err, "R2",
              "idle outputs in reset", {in_service, mem_we, mem_re, pc_load, mode_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!in_service && iff1 && iff2, "R2", "state after reset release", {in_service, iff1, iff2}, 3);

        pc = 16'h1234; sp = 16'h8000; page = 8'h40; bus_byte = 8'h11;
        one_irq(2'd0, "R8");                  // mode 0 after reset
        set_mode(2'd1);
        pc = 16'hBEEF; sp = 16'h0100;
        one_irq(2'd1, "R7");
        set_mode(2'd2);
        pc = 16'hCAFE; page = 8'h3C; bus_byte = 8'h24;
        one_irq(2'd2, "R9");
        bus_byte = 8'hFF;                     // R9 offset bit 0 forced low
        one_irq(2'd2, "R9");
        set_mode(2'd3);
        bus_byte = 8'h81; pc = 16'h00FF;
        one_irq(2'd3, "R7");

        // R6 / R1 non-maskable
        set_mode(2'd1);
        pc = 16'h4567; sp = 16'h2000;
        expect_service(1'b1, 2'd1, "R6");
        pulse(1'b1, 1'b0);
        check(!iff1 && iff2, "R1", "nmi clears only IFF1", {iff1, iff2}, 1);
        drain("R6");

        // R3 masked request dropped
        pulse(1'b0, 1'b1);
        @(negedge clk);
        check(!in_service, "R3", "masked request ignored", in_service, 0);
        drain("R3");

        // R12 enable write
        set_ie(1'b1);
        check(iff1 && iff2, "R12", "enable write sets both flags", {iff1, iff2}, 3);

        // R5 stack wrap
        sp = 16'h0001; pc = 16'hA55A;
        one_irq(2'd1, "R5");

        // R11 both together
        sp = 16'h3000; pc = 16'h7777;
        expect_service(1'b1, 2'd1, "R11");
        expect_service(1'b0, 2'd1, "R11");
        pulse(1'b1, 1'b1);
        drain("R11");

        // R12 nmi beats enable write
        @(negedge clk); ie_we = 1'b1; ie_val = 1'b1; nmi_req = 1'b1;
        expect_service(1'b1, 2'd1, "R12");
        @(negedge clk); ie_we = 1'b0; nmi_req = 1'b0;
        check(!iff1 && iff2, "R12", "nmi wins over enable write", {iff1, iff2}, 1);
        drain("R12");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL R10 watchdog expired: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule